// File: doc/BRIEF.md
# Split Program Counter Fetch Sequencer

This block fetches instructions for a small CPU whose program and data memories are separate. The program counter is held in two registers. The leading register (the master) holds the address of the instruction now in the instruction register. The trailing register (the slave) drives the program-memory address. An instruction cycle advances only when the `step` strobe is high for one clock. In each ordinary cycle the word at the slave address is loaded into the instruction register, the master takes the slave value, and the slave moves one address ahead.

A load-constant instruction borrows the slave register for one cycle. It points the slave at the low bits of a pointer register while the master keeps the instruction address. On the following step the word read from program memory goes into the link register, and the instruction register is cleared so that the cycle runs as a no-operation. The slave is then rebuilt from the master plus one, and fetching continues after the load-constant. Jumps, calls and returns place a new address in the slave and clear the instruction register, so the word fetched after a control transfer is dropped. A call also writes its return address into the link register through the same path. A return reloads the slave from the link register without adding one, so no instruction is skipped.

The controller has two states. `ST_SEQ` is ordinary sequencing; a step with class load-constant moves it to `ST_CONST`. `ST_CONST` is the constant-fetch cycle; any step returns it to `ST_SEQ`.

Top module: `pc_fetch_seq`

## Requirements
- R1: After reset `prog_addr`, `instr` and `link_word` are all zero, so the first instruction is fetched from address 0.
- R2: A step in `ST_SEQ` with class 0 (sequential) loads `instr` with the word at the current `prog_addr`. `prog_addr` then advances by one and wraps from 4095 to 0. Class codes 5 to 7 behave like class 0.
- R3: A step in `ST_SEQ` with class 1 (load-constant) sets `prog_addr` to `ptr_reg[11:0]` and ignores `ptr_reg[15:12]`. `instr` and `link_word` are left unchanged.
- R4: The step after a load-constant loads `link_word` with the program word at the borrowed address and clears `instr` to 0x0000 (no-operation). The class input is ignored on that step.
- R5: After the constant-fetch step, `prog_addr` equals the load-constant's own address plus one. The next step loads that instruction.
- R6: A step with class 2 (jump) sets `prog_addr` to `jump_tgt` and clears `instr`. The next sequential step loads the word at the target.
- R7: A step with class 3 (call) does what a jump does. It also sets `link_word` to the zero-extended address of the call plus one.
- R8: A step with class 4 (return) sets `prog_addr` to `link_word[11:0]` without increment and clears `instr`. The next sequential step loads the word at that address.
- R9: While `step` is low, `prog_addr`, `instr` and `link_word` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One-clock strobe that advances one instruction cycle |
| op_class | input | 3 | Decoded class of the instruction in `instr` |
| ptr_reg | input | 16 | Selected pointer register value for load-constant |
| jump_tgt | input | 12 | Target address for jump and call |
| prog_data | input | 16 | Program-memory word at `prog_addr` |
| prog_addr | output | 12 | Program-memory address (slave register) |
| instr | output | 16 | Instruction register |
| link_word | output | 16 | Constant / return-address register |

## Verification
The bench goes after the borrowed-address path. A design that advanced the master during the constant cycle would resume one instruction late. One that reloaded `instr` would execute the constant as code. The bench sets the upper pointer bits so that a design using them would address the wrong word. It also runs returns straight after calls to catch an extra increment, which would skip the instruction after the call. Further checks cover wrap at the top of the address space and idle clocks between steps.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [2:0] {
        OPC_SEQ   = 3'd0,
        OPC_CONST = 3'd1,
        OPC_JUMP  = 3'd2,
        OPC_CALL  = 3'd3,
        OPC_RET   = 3'd4
    } op_class_e;

    typedef enum logic {
        ST_SEQ   = 1'b0,
        ST_CONST = 1'b1
    } fetch_state_e;

    typedef enum logic [2:0] {
        SL_HOLD,
        SL_ADVANCE,
        SL_RESTORE,
        SL_PTR,
        SL_JUMP,
        SL_LINK
    } slave_sel_e;

    typedef enum logic [1:0] {
        IR_HOLD,
        IR_LOAD,
        IR_CLEAR
    } ir_act_e;

    typedef enum logic [1:0] {
        LK_HOLD,
        LK_CODE,
        LK_RETURN
    } link_act_e;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  op_class_e    cls,
    output fetch_state_e state,
    output slave_sel_e   slave_sel,
    output ir_act_e      ir_act,
    output link_act_e    link_act
);

    fetch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEQ;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        slave_sel = SL_HOLD;
        ir_act    = IR_HOLD;
        link_act  = LK_HOLD;
        if (step) begin
            unique case (state_q)
                ST_SEQ: begin
                    unique case (cls)
                        OPC_CONST: begin
                            slave_sel = SL_PTR;
                            state_d   = ST_CONST;
                        end
                        OPC_JUMP: begin
                            slave_sel = SL_JUMP;
                            ir_act    = IR_CLEAR;
                        end
                        OPC_CALL: begin
                            slave_sel = SL_JUMP;
                            ir_act    = IR_CLEAR;
                            link_act  = LK_RETURN;
                        end
                        OPC_RET: begin
                            slave_sel = SL_LINK;
                            ir_act    = IR_CLEAR;
                        end
                        default: begin
                            slave_sel = SL_ADVANCE;
                            ir_act    = IR_LOAD;
                        end
                    endcase
                end
                ST_CONST: begin
                    slave_sel = SL_RESTORE;
                    ir_act    = IR_CLEAR;
                    link_act  = LK_CODE;
                    state_d   = ST_SEQ;
                end
                default: state_d = ST_SEQ;
            endcase
        end
    end

    assign state = state_q;

    assert_const_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONST && step) |=> (state_q == ST_SEQ));

    assert_const_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEQ && step && cls == OPC_CONST) |=> (state_q == ST_CONST));

endmodule

// File: rtl/pc_pair.sv
module pc_pair
    import fetch_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  slave_sel_e      sel,
    input  logic [PC_W-1:0] ptr_addr,
    input  logic [PC_W-1:0] jump_addr,
    input  logic [PC_W-1:0] link_addr,
    output logic [PC_W-1:0] master,
    output logic [PC_W-1:0] slave
);

    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic [PC_W-1:0] master_q, slave_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= '0;
            slave_q  <= '0;
        end else begin
            unique case (sel)
                SL_ADVANCE: begin
                    master_q <= slave_q;
                    slave_q  <= slave_q + ONE;
                end
                SL_RESTORE: slave_q <= master_q + ONE;
                SL_PTR:     slave_q <= ptr_addr;
                SL_JUMP:    slave_q <= jump_addr;
                SL_LINK:    slave_q <= link_addr;
                default:    ;
            endcase
        end
    end

    assign master = master_q;
    assign slave  = slave_q;

    assert_slave_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SL_ADVANCE) |=> (slave_q == master_q + ONE));

    assert_master_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SL_ADVANCE) |=> $stable(master_q));

endmodule

// File: rtl/word_regs.sv
module word_regs
    import fetch_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ir_act_e           ir_act,
    input  link_act_e         link_act,
    input  logic [WORD_W-1:0] code_word,
    input  logic [PC_W-1:0]   ret_addr,
    output logic [WORD_W-1:0] instr,
    output logic [WORD_W-1:0] link_word
);

    logic [WORD_W-1:0] ir_q, link_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= '0;
            link_q <= '0;
        end else begin
            unique case (ir_act)
                IR_LOAD:  ir_q <= code_word;
                IR_CLEAR: ir_q <= '0;
                default:  ;
            endcase
            unique case (link_act)
                LK_CODE:   link_q <= code_word;
                LK_RETURN: link_q <= WORD_W'(ret_addr);
                default:   ;
            endcase
        end
    end

    assign instr     = ir_q;
    assign link_word = link_q;

    assert_ret_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_act == LK_RETURN) |=> (link_q[WORD_W-1:PC_W] == '0));

endmodule

// File: rtl/pc_fetch_seq.sv
module pc_fetch_seq
    import fetch_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [2:0]        op_class,
    input  logic [WORD_W-1:0] ptr_reg,
    input  logic [PC_W-1:0]   jump_tgt,
    input  logic [WORD_W-1:0] prog_data,
    output logic [PC_W-1:0]   prog_addr,
    output logic [WORD_W-1:0] instr,
    output logic [WORD_W-1:0] link_word
);

    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    op_class_e    cls;
    fetch_state_e state;
    slave_sel_e   slave_sel;
    ir_act_e      ir_act;
    link_act_e    link_act;
    logic [PC_W-1:0] master, slave;
    logic unused_ptr_hi;

    assign cls           = op_class_e'(op_class);
    assign unused_ptr_hi = ^ptr_reg[WORD_W-1:PC_W];

    fetch_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .cls       (cls),
        .state     (state),
        .slave_sel (slave_sel),
        .ir_act    (ir_act),
        .link_act  (link_act)
    );

    pc_pair #(.PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (slave_sel),
        .ptr_addr  (ptr_reg[PC_W-1:0]),
        .jump_addr (jump_tgt),
        .link_addr (link_word[PC_W-1:0]),
        .master    (master),
        .slave     (slave)
    );

    word_regs #(.WORD_W(WORD_W), .PC_W(PC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_act    (ir_act),
        .link_act  (link_act),
        .code_word (prog_data),
        .ret_addr  (master + ONE),
        .instr     (instr),
        .link_word (link_word)
    );

    assign prog_addr = slave;

    assert_ldc_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state == ST_SEQ && cls == OPC_CONST)
        |=> (prog_addr == $past(ptr_reg[PC_W-1:0])) && $stable(instr) && $stable(link_word));

    assert_const_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state == ST_CONST)
        |=> (instr == '0) && (link_word == $past(prog_data)));

    assert_jump_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state == ST_SEQ && cls == OPC_JUMP)
        |=> (prog_addr == $past(jump_tgt)) && (instr == '0));

    assert_ret_no_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state == ST_SEQ && cls == OPC_RET)
        |=> (prog_addr == $past(link_word[PC_W-1:0])) && (instr == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step) |=> $stable(prog_addr) && $stable(instr) && $stable(link_word));

endmodule

// File: tb/sim_pc_fetch_seq.sv
module sim_pc_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic [15:0] ptr_reg = '0;
    logic [11:0] jump_tgt = '0;
    logic [15:0] prog_data;
    logic [11:0] prog_addr;
    logic [15:0] instr, link_word;

    int checks = 0;
    int errors = 0;

    logic [11:0] m_master, m_slave;
    logic [15:0] m_ir, m_link;
    bit          m_const;

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [11:0] a);
        logic [31:0] h;
        h = {20'd0, a} * 32'd40503 + 32'h1357;
        return h[15:0] ^ {a[3:0], a};
    endfunction

    assign prog_data = mem_word(prog_addr);

    pc_fetch_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .op_class  (op_class),
        .ptr_reg   (ptr_reg),
        .jump_tgt  (jump_tgt),
        .prog_data (prog_data),
        .prog_addr (prog_addr),
        .instr     (instr),
        .link_word (link_word)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "prog_addr", {4'd0, prog_addr}, {4'd0, m_slave});
        chk(tag, "instr", instr, m_ir);
        chk(tag, "link_word", link_word, m_link);
    endtask

    // expected next state from the requirements
    task automatic model_step(input logic [2:0] c, input logic [15:0] p, input logic [11:0] t);
        if (m_const) begin
            m_link  = mem_word(m_slave);
            m_ir    = '0;
            m_slave = m_master + 12'd1;
            m_const = 0;
        end else begin
            case (c)
                3'd1: begin m_slave = p[11:0]; m_const = 1; end
                3'd2: begin m_slave = t; m_ir = '0; end
                3'd3: begin m_link = {4'd0, m_master + 12'd1}; m_slave = t; m_ir = '0; end
                3'd4: begin m_slave = m_link[11:0]; m_ir = '0; end
                default: begin m_ir = mem_word(m_slave); m_master = m_slave; m_slave = m_slave + 12'd1; end
            endcase
        end
    endtask

    task automatic do_step(input logic [2:0] c, input logic [15:0] p, input logic [11:0] t, input string tag);
        @(negedge clk);
        op_class = c; ptr_reg = p; jump_tgt = t; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        model_step(c, p, t);
        chk_all(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_class = 3'($urandom); ptr_reg = 16'($urandom); jump_tgt = 12'($urandom);
        end
        @(negedge clk);
        chk_all("R9");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_master = '0; m_slave = '0; m_ir = '0; m_link = '0; m_const = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R2 sequential fetch from zero
        for (int i = 0; i < 4; i++) do_step(3'd0, 16'h0, 12'h0, "R2");
        // R3 load-constant, upper pointer bits set
        do_step(3'd1, 16'hF123, 12'h0, "R3");
        // R4 constant cycle, class input (jump) ignored
        do_step(3'd2, 16'h0, 12'h777, "R4");
        // R5 resume after the load-constant
        do_step(3'd0, 16'h0, 12'h0, "R5");
        // R6 jump near the top, then wrap (R2)
        do_step(3'd2, 16'h0, 12'hFFE, "R6");
        do_step(3'd0, 16'h0, 12'h0, "R6");
        do_step(3'd0, 16'h0, 12'h0, "R2");
        do_step(3'd0, 16'h0, 12'h0, "R2");
        // R7 call, R8 return
        do_step(3'd3, 16'h0, 12'h200, "R7");
        for (int i = 0; i < 3; i++) do_step(3'd0, 16'h0, 12'h0, "R7");
        do_step(3'd4, 16'h0, 12'h0, "R8");
        do_step(3'd0, 16'h0, 12'h0, "R8");
        // unknown class behaves as sequential
        do_step(3'd6, 16'h0, 12'h0, "R2");
        idle(5);

        for (int i = 0; i < 500; i++) begin
            int r;
            logic [2:0] c;
            string tag;
            r = int'($urandom % 10);
            c = (r < 5) ? 3'd0 : (r == 5) ? 3'd1 : (r == 6) ? 3'd2 :
                (r == 7) ? 3'd3 : (r == 8) ? 3'd4 : 3'd7;
            if (m_const)        tag = "R4";
            else if (c == 3'd1) tag = "R3";
            else if (c == 3'd2) tag = "R6";
            else if (c == 3'd3) tag = "R7";
            else if (c == 3'd4) tag = "R8";
            else                tag = "R2";
            do_step(c, 16'($urandom), 12'($urandom), tag);
            if ((i % 37) == 0) idle(2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule